// File: doc/BRIEF.md
# Keyed Hamming Cipher Encoder

This block turns a stream of 8-bit characters into pairs of 9-bit cipher words. Each accepted character is split into its low and high nibbles, which are handled side by side in two identical lanes. In each lane the nibble is XORed with part of a key, expanded into a (7,4) Hamming codeword and then deliberately damaged in exactly one bit, so a receiver that holds the same keys can still recover the nibble with an ordinary single-error corrector. A two-bit code-type tag is placed in front of each codeword so that the receiver can tell which decoder to use.

Three 8-bit keys are captured while the synchronous reset is high. After every encoded character all three keys rotate left by one bit, so a character that repeats in the message gives different cipher words. A zero character ends the message: it produces no output, and the block then refuses further input until it is reset again.

The input is a valid/ready byte port that takes one character per cycle. Both output words are registered and come with a single valid strobe one cycle after the character is taken.

Top module: `keyed_hamming_enc`

## Requirements
- R1: While `rst` is high at a rising edge, the block captures `keyA`, `keyB` and `keyC` as its working keys, clears `outValid`, `outLo` and `outHi` to zero, and re-opens the input, so that `inReady` is 1 after reset.
- R2: The low nibble `inChar[3:0]` is XORed with bits [3:0] of the working A key. The high nibble `inChar[7:4]` is XORed with bits [7:4] of the working B key.
- R3: A whitened nibble d with d1 = d[3], d2 = d[2], d3 = d[1], d4 = d[0] is encoded as the 7-bit codeword {p1,p2,d1,p3,d2,d3,d4}, where bit 6 is position 1. The parity bits are p1 = d1^d2^d4, p2 = d1^d3^d4 and p3 = d2^d3^d4.
- R4: Exactly one bit of each codeword is inverted, at position (f mod 7)+1, which is bit index 7-((f mod 7)+1). For the low lane, f is bits [2:0] of the working C key. For the high lane, f is bits [6:4] of the working C key.
- R5: Each output word is {2'b01, damaged codeword}. `outLo` comes from the low nibble and `outHi` from the high nibble.
- R6: `outValid` is high for exactly the one cycle after a nonzero character is taken. In every other cycle `outValid` is low and `outLo`/`outHi` keep their previous values.
- R7: After every nonzero character that is taken, all three working keys rotate left by one bit ({k[6:0],k[7]}). Idle cycles leave the keys unchanged.
- R8: A taken zero character produces no output word. From the next cycle `inReady` stays low until reset, and any later input has no effect on the outputs.
- R9: With `inValid` held high, a new character is taken on every cycle, and every one of them produces its own output pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the keys |
| keyA | input | 8 | Whitening key for the low nibble, captured in reset |
| keyB | input | 8 | Whitening key for the high nibble, captured in reset |
| keyC | input | 8 | Error-position key, captured in reset |
| inValid | input | 1 | Input character is valid |
| inChar | input | 8 | Input character; zero ends the message |
| inReady | output | 1 | Block accepts a character this cycle |
| outValid | output | 1 | Output word pair is new this cycle |
| outLo | output | 9 | Tagged cipher word for the low nibble |
| outHi | output | 9 | Tagged cipher word for the high nibble |

## Verification
Any fault in the working keys shows up in the very next output pair after the damage. A missed or extra rotation moves the whitening bits and the error position, so it garbles every later word, and an idle cycle that wrongly advances the keys is exposed by the first character after it. A fault in the end-of-message state shows at `inReady` one cycle after the zero character, or as a stray `outValid` when stimulus keeps arriving after the stop. Errors in the parity equations or the flip mask change the same cycle's output word against a model built only from the stated bit order.

// File: rtl/khe_pkg.sv
package khe_pkg;
  localparam int CHAR_W = 8;
  localparam int NIB_W  = 4;
  localparam int CW_W   = 7;
  localparam int TAG_W  = 2;
  localparam int OUT_W  = TAG_W + CW_W;
  localparam int FLD_W  = 3;
  localparam int LANES  = CHAR_W / NIB_W;
  localparam int NKEYS  = 3;

  typedef struct packed {
    logic loadKeys;
    logic encode;
  } khe_strobe_t;

  // (7,4) codeword, position 1 at the MSB: p1 p2 d1 p3 d2 d3 d4
  function automatic logic [CW_W-1:0] hamEncode(input logic [NIB_W-1:0] d);
    logic p1, p2, p3;
    p1 = d[3] ^ d[2] ^ d[0];
    p2 = d[3] ^ d[1] ^ d[0];
    p3 = d[2] ^ d[1] ^ d[0];
    return {p1, p2, d[3], p3, d[2], d[1], d[0]};
  endfunction
endpackage

// File: rtl/khe_ctrl.sv
module khe_ctrl
  import khe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CHAR_W-1:0] inChar,
  output logic              inReady,
  output khe_strobe_t       strb
);
  logic stopped;
  logic take;
  logic isZero;

  assign inReady = !stopped;
  assign take    = inValid && inReady;
  assign isZero  = (inChar == '0);

  always_ff @(posedge clk) begin
    if (rst)                stopped <= 1'b0;
    else if (take && isZero) stopped <= 1'b1;
  end

  always_comb begin
    strb.loadKeys = rst;
    strb.encode   = take && !isZero && !rst;
  end

  AST_STOP_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (take && isZero) |=> !inReady); // R8
  AST_STAY_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> !inReady); // R8
  AST_NO_ENCODE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> !strb.encode); // R8
endmodule

// File: rtl/khe_lane.sv
module khe_lane
  import khe_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic [NIB_W-1:0] keyNib,
  input  logic [FLD_W-1:0] errField,
  output logic [CW_W-1:0]  word
);
  localparam logic [CW_W-1:0] TOP_BIT = {1'b1, {(CW_W-1){1'b0}}};

  logic [NIB_W-1:0] whitened;
  logic [CW_W-1:0]  clean;
  logic [FLD_W-1:0] shift;
  logic [CW_W-1:0]  errMask;

  always_comb begin
    whitened = nib ^ keyNib;
    clean    = hamEncode(whitened);
    // field value 7 wraps to position 1
    shift    = (errField == FLD_W'(CW_W)) ? '0 : errField;
    errMask  = TOP_BIT >> shift;
    word     = clean ^ errMask;
  end

  always_comb begin
    if (!$isunknown({nib, keyNib, errField})) begin
      AST_ONE_FLIP: assert ($countones(word ^ hamEncode(nib ^ keyNib)) == 1); // R4
    end
  end
endmodule

// File: rtl/khe_datapath.sv
module khe_datapath
  import khe_pkg::*;
#(
  parameter logic [TAG_W-1:0] TAG = 2'b01
) (
  input  logic              clk,
  input  khe_strobe_t       strb,
  input  logic [CHAR_W-1:0] inChar,
  input  logic [CHAR_W-1:0] keyAIn,
  input  logic [CHAR_W-1:0] keyBIn,
  input  logic [CHAR_W-1:0] keyCIn,
  output logic              outValid,
  output logic [OUT_W-1:0]  outLo,
  output logic [OUT_W-1:0]  outHi
);
  localparam int ERR_KEY = NKEYS - 1;

  logic [CHAR_W-1:0] keyIn  [NKEYS];
  logic [CHAR_W-1:0] keyReg [NKEYS];
  logic [CW_W-1:0]   laneWord [LANES];
  logic [OUT_W-1:0]  outWord  [LANES];

  assign keyIn[0] = keyAIn;
  assign keyIn[1] = keyBIn;
  assign keyIn[2] = keyCIn;

  for (genvar k = 0; k < NKEYS; k++) begin : gKey
    always_ff @(posedge clk) begin
      if (strb.loadKeys)    keyReg[k] <= keyIn[k];
      else if (strb.encode) keyReg[k] <= {keyReg[k][CHAR_W-2:0], keyReg[k][CHAR_W-1]};
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : gLane
    khe_lane uLane (
      .nib      (inChar[l*NIB_W +: NIB_W]),
      .keyNib   (keyReg[l][l*NIB_W +: NIB_W]),
      .errField (keyReg[ERR_KEY][l*NIB_W +: FLD_W]),
      .word     (laneWord[l])
    );

    always_ff @(posedge clk) begin
      if (strb.loadKeys)    outWord[l] <= '0;
      else if (strb.encode) outWord[l] <= {TAG, laneWord[l]};
    end
  end

  always_ff @(posedge clk) begin
    if (strb.loadKeys) outValid <= 1'b0;
    else               outValid <= strb.encode;
  end

  assign outLo = outWord[0];
  assign outHi = outWord[1];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (strb.loadKeys)
    strb.encode |=> outValid); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (strb.loadKeys)
    !strb.encode |=> (!outValid && $stable(outLo) && $stable(outHi))); // R6
  AST_TAG_PRESENT: assert property (@(posedge clk) disable iff (strb.loadKeys)
    outValid |-> (outLo[OUT_W-1 -: TAG_W] == TAG && outHi[OUT_W-1 -: TAG_W] == TAG)); // R5
  AST_KEYS_HOLD: assert property (@(posedge clk) disable iff (strb.loadKeys)
    !strb.encode |=> ($stable(keyReg[0]) && $stable(keyReg[1]) && $stable(keyReg[2]))); // R7
endmodule

// File: rtl/keyed_hamming_enc.sv
module keyed_hamming_enc
  import khe_pkg::*;
#(
  parameter logic [TAG_W-1:0] TAG = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] keyA,
  input  logic [CHAR_W-1:0] keyB,
  input  logic [CHAR_W-1:0] keyC,
  input  logic              inValid,
  input  logic [CHAR_W-1:0] inChar,
  output logic              inReady,
  output logic              outValid,
  output logic [OUT_W-1:0]  outLo,
  output logic [OUT_W-1:0]  outHi
);
  khe_strobe_t strb;

  khe_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inChar  (inChar),
    .inReady (inReady),
    .strb    (strb)
  );

  khe_datapath #(.TAG(TAG)) uPath (
    .clk      (clk),
    .strb     (strb),
    .inChar   (inChar),
    .keyAIn   (keyA),
    .keyBIn   (keyB),
    .keyCIn   (keyC),
    .outValid (outValid),
    .outLo    (outLo),
    .outHi    (outHi)
  );
endmodule

// File: tb/tb_keyed_hamming_enc.sv
module tb_keyed_hamming_enc;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic [7:0] keyA = '0, keyB = '0, keyC = '0;
  logic       inValid = 1'b0;
  logic [7:0] inChar = '0;
  logic       inReady, outValid;
  logic [8:0] outLo, outHi;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic [7:0] mA, mB, mC;
  logic       expValid, expReady;
  logic [8:0] expLo, expHi;

  always #4 clk = ~clk; // 125 MHz

  keyed_hamming_enc dut (
    .clk(clk), .rst(rst), .keyA(keyA), .keyB(keyB), .keyC(keyC),
    .inValid(inValid), .inChar(inChar), .inReady(inReady),
    .outValid(outValid), .outLo(outLo), .outHi(outHi)
  );

  function automatic logic [6:0] refHam(input logic [3:0] d);
    // R3: {p1,p2,d1,p3,d2,d3,d4}, d1 = d[3]
    logic d1, d2, d3, d4;
    d1 = d[3]; d2 = d[2]; d3 = d[1]; d4 = d[0];
    return {d1 ^ d2 ^ d4, d1 ^ d3 ^ d4, d1, d2 ^ d3 ^ d4, d2, d3, d4};
  endfunction

  function automatic logic [8:0] refWord(input logic [3:0] nib, input logic [3:0] kn,
                                         input logic [2:0] f);
    int pos;
    logic [6:0] cw;
    cw  = refHam(nib ^ kn);            // R2
    pos = (int'(f) % 7) + 1;           // R4
    cw[7 - pos] = ~cw[7 - pos];
    return {2'b01, cw};                // R5
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] k);
    return {k[6:0], k[7]};             // R7
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge: check the previous cycle's outcome, then drive.
  task automatic step(input bit v, input logic [7:0] c, input string req);
    chk({req, " outValid R6"}, 32'(outValid), 32'(expValid));
    chk({req, " outLo R2 R3 R4 R5"}, 32'(outLo), 32'(expLo));
    chk({req, " outHi R2 R3 R4 R5"}, 32'(outHi), 32'(expHi));
    chk({req, " inReady R8"}, 32'(inReady), 32'(expReady));
    inValid = v;
    inChar  = c;
    if (v && expReady && c != 8'h00) begin
      expValid = 1'b1;
      expLo = refWord(c[3:0], mA[3:0], mC[2:0]);
      expHi = refWord(c[7:4], mB[7:4], mC[6:4]);
      mA = rotl(mA); mB = rotl(mB); mC = rotl(mC);
    end else begin
      expValid = 1'b0;
      if (v && expReady) expReady = 1'b0; // zero terminator, R8
    end
    @(negedge clk);
  endtask

  task automatic doReset(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    inValid = 1'b0;
    keyA = a; keyB = b; keyC = c;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    keyA = ~a; keyB = ~b; keyC = ~c; // keys only matter during reset, R1
    mA = a; mB = b; mC = c;
    expValid = 1'b0; expReady = 1'b1; expLo = '0; expHi = '0;
    chk("R1 reset outValid", 32'(outValid), 32'd0);
    chk("R1 reset outLo", 32'(outLo), 32'd0);
    chk("R1 reset inReady", 32'(inReady), 32'd1);
  endtask

  function automatic logic [7:0] randChar();
    logic [7:0] c;
    c = 8'($urandom_range(1, 255));
    return c;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    doReset(8'd15, 8'd14, 8'd200);

    // directed: single char then idle cycles, R6 and R7
    step(1, 8'd84, "dir T");
    step(0, 8'd0, "idle after T");
    step(0, 8'd0, "idle2");
    // repeated char back to back: keys rotate so words differ, R7 R9
    for (int i = 0; i < 8; i++) step(1, 8'h41, "repeat R7 R9");
    step(0, 8'd0, "idle");

    // random stream with idle gaps, R9
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 4) == 0) step(0, randChar(), "rand idle R7");
      else                           step(1, randChar(), "rand R9");
    end

    // terminator and ignored stimulus, R8
    step(1, 8'h00, "zero char R8");
    for (int i = 0; i < 6; i++) step(1, randChar(), "after stop R8");
    step(0, 8'd0, "stopped idle R8");

    // error field value 7 wraps to position 1, field 0 also position 1, R4
    doReset(8'h3C, 8'hA5, 8'h77);
    step(1, 8'h00 | 8'h5A, "field7 R4");
    step(1, 8'hFF, "field R4");
    step(0, 8'd0, "idle");
    doReset(8'h00, 8'h00, 8'h00);
    step(1, 8'h01, "field0 R4");
    for (int i = 0; i < 16; i++) step(1, 8'h80, "rot R7");
    step(0, 8'd0, "idle");

    // fresh random keys, R1 reload after stop
    for (int r = 0; r < 4; r++) begin
      doReset(8'($urandom), 8'($urandom), 8'($urandom));
      for (int i = 0; i < 60; i++) begin
        if ($urandom_range(0, 3) == 0) step(0, randChar(), "rand2 idle");
        else                           step(1, randChar(), "rand2 R9");
      end
      step(1, 8'h00, "zero2 R8");
      step(1, 8'h22, "after stop2 R8");
      step(0, 8'd0, "end R8");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule